// File: doc/BRIEF.md
# Programmable Event Delay Line

This block turns time into position for an event-driven processing chain. It holds a row of delay elements, each of which can carry one pulse. An incoming address event places a pulse in the element that the address names. At every advance step, each pulse leaves its element and moves on to the next one. An advance step happens once per element crossing time, which is a fixed number of unit stages multiplied by a programmable unit length in clock cycles. Every element that a pulse leaves reports an output address event carrying that element's index. A downstream stage can therefore read how long ago an input arrived from where the pulse now reports.

A cut mask, written through a word-wide configuration port, can break the row between any two neighbouring elements. This splits it into independent lines. A pulse that reaches a broken boundary, or the final element, reports its event and then disappears. Output events that fall in the same step are gathered in a pending set. They go into a small queue one per cycle, lowest address first. The queue is read through a request/acknowledge pair. Events that find the queue full are dropped and counted.

Top module: `event_delay_line`

## Requirements
- R1: After reset no element holds a pulse, `out_req` is low, `ovf_count` is zero, every boundary is connected, and the unit length is `UNIT_RST`.
- R2: A cycle with `in_valid` high and `in_addr` below `N_ELEM` puts a pulse in element `in_addr`. An address of `N_ELEM` or above has no effect.
- R3: A phase counter starts at 0 after reset, counts clock cycles, and an advance step occurs in the cycle where it equals `STAGES*unit-1`, after which it restarts at 0. In a step, each occupied element `i` is vacated and reports an event with address `i`. A pulse injected in the step cycle itself is not advanced.
- R4: A pulse leaving element `i` enters element `i+1` unless `i` is the last element or boundary `i` is broken. Boundary `i` is bit `i mod 32` of configuration word `1 + i/32`, and a 1 there means broken.
- R5: Pulses that land in the same element in the same cycle, whether injected onto an occupied element or injected where a pulse is moving in, merge into one pulse.
- R6: Each cycle the lowest-addressed pending event is removed from the pending set and offered to the queue. An event reported by a step reaches `out_addr` no earlier than two cycles after the step's clock edge. Events from one step leave the queue in rising address order.
- R7: `out_req` is high exactly while the queue holds an entry, and `out_addr` shows the oldest entry. That entry is removed in a cycle where `out_req` and `out_ack` are both high. While `out_req` is high and `out_ack` is low, `out_addr` is held.
- R8: When the queue holds `FIFO_DEPTH` entries at the start of a cycle, the event offered in that cycle is discarded and `ovf_count` increases by one, saturating at its maximum. This holds even if the head is accepted in that same cycle.
- R9: Writing configuration word 0 with a nonzero value in its low `UNIT_W` bits sets the unit length and restarts the phase counter at 0. A zero value there leaves both unchanged.
- R10: A configuration write to a word index above the last cut-mask word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input event present this cycle |
| in_addr | input | 10 | Element that receives the pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration word index (0 = unit length, 1.. = cut mask) |
| cfg_wdata | input | 32 | Configuration write data |
| out_req | output | 1 | Queue holds an output event |
| out_ack | input | 1 | Consumer takes the head event |
| out_addr | output | 10 | Address of the head output event |
| ovf_count | output | 16 | Count of dropped output events |

## Verification
Two events can coincide in one cycle. An input pulse can arrive in the same cycle as an advance step, and the queue can refuse a push while its head is being accepted. To provoke the first case, the stimulus injects pulses back to back across step boundaries and onto elements that a moving pulse enters at that step. To provoke the second, the stimulus holds `out_ack` low until the queue fills and then releases it with pending events still waiting. A behavioural model built from plain bit arrays and a queue applies the requirements in their stated order every cycle. The request, head address and drop count are compared against that model on every falling edge.

// File: rtl/edl_pkg.sv
package edl_pkg;
    // Width of one configuration word.
    localparam int CFG_DW       = 32;
    // Word index that carries the unit length.
    localparam int CFG_UNIT_SEL = 0;
    // First word index of the cut mask.
    localparam int CFG_CUT_BASE = 1;
endpackage

// File: rtl/edl_cfg.sv
module edl_cfg #(
    parameter int N_ELEM   = 880,
    parameter int UNIT_W   = 8,
    parameter int UNIT_RST = 1,
    parameter int SEL_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [edl_pkg::CFG_DW-1:0] cfg_wdata,
    output logic [UNIT_W-1:0]         unit,
    output logic                      unit_load,
    output logic [N_ELEM-2:0]         cut
);
    import edl_pkg::*;

    localparam int N_LINK = N_ELEM - 1;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [N_LINK-1:0] cut;
    } cfg_s;

    cfg_s s_d, s_q;
    logic load_d;

    always_comb begin
        s_d    = s_q;
        load_d = 1'b0;
        if (cfg_we) begin
            if (cfg_sel == SEL_W'(CFG_UNIT_SEL)) begin
                if (cfg_wdata[UNIT_W-1:0] != '0) begin
                    s_d.unit = cfg_wdata[UNIT_W-1:0];
                    load_d   = 1'b1;
                end
            end
            for (int i = 0; i < N_LINK; i++) begin
                if (cfg_sel == SEL_W'(CFG_CUT_BASE + i / CFG_DW))
                    s_d.cut[i] = cfg_wdata[i % CFG_DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{unit: UNIT_W'(UNIT_RST), cut: '0};
        else        s_q <= s_d;
    end

    assign unit      = s_q.unit;
    assign cut       = s_q.cut;
    assign unit_load = load_d;

    // R9: the stored unit length can never become zero
    assert_unit_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.unit != '0);
endmodule

// File: rtl/edl_cascade.sv
module edl_cascade #(
    parameter int N_ELEM = 880,
    parameter int STAGES = 16,
    parameter int UNIT_W = 8,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] unit,
    input  logic              unit_load,
    input  logic [N_ELEM-2:0] cut,
    input  logic              inj_valid,
    input  logic [AW-1:0]     inj_addr,
    output logic [N_ELEM-1:0] leave
);
    localparam int PH_W = $clog2(STAGES * (2 ** UNIT_W));

    typedef struct packed {
        logic [N_ELEM-1:0] occ;
        logic [PH_W-1:0]   phase;
    } casc_s;

    casc_s s_d, s_q;
    logic [PH_W-1:0]   period_m1;
    logic              step;
    logic [N_ELEM-1:0] moved;

    assign period_m1 = PH_W'(STAGES * int'(unit) - 1);

    always_comb begin
        s_d   = s_q;
        step  = (s_q.phase >= period_m1);
        leave = step ? s_q.occ : '0;
        moved = '0;
        for (int i = 1; i < N_ELEM; i++)
            moved[i] = leave[i-1] & ~cut[i-1];
        if (step) s_d.occ = moved;
        for (int i = 0; i < N_ELEM; i++) begin
            if (inj_valid && inj_addr == AW'(i))
                s_d.occ[i] = 1'b1;
        end
        if (unit_load)  s_d.phase = '0;
        else if (step)  s_d.phase = '0;
        else            s_d.phase = s_q.phase + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: phase never runs past the end of one element crossing
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= period_m1);

    // R3: outside a step and with no injection, the occupancy is frozen
    assert_occ_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !inj_valid) |=> $stable(s_q.occ));
endmodule

// File: rtl/edl_emit.sv
module edl_emit #(
    parameter int N_ELEM     = 880,
    parameter int AW         = 10,
    parameter int FIFO_DEPTH = 8,
    parameter int OVF_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ELEM-1:0] leave,
    input  logic              out_ack,
    output logic              out_req,
    output logic [AW-1:0]     out_addr,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [N_ELEM-1:0]               pend;
        logic [FIFO_DEPTH-1:0][AW-1:0]   mem;
        logic [PW-1:0]                   rd;
        logic [PW-1:0]                   wr;
        logic [CW-1:0]                   cnt;
        logic [OVF_W-1:0]                ovf;
    } emit_s;

    emit_s s_d, s_q;
    logic              found, full, pop, push, drop;
    logic [AW-1:0]     low_idx;
    logic [N_ELEM-1:0] low_oh;

    always_comb begin
        s_d     = s_q;
        found   = (s_q.pend != '0);
        low_idx = '0;
        for (int i = N_ELEM - 1; i >= 0; i--)
            if (s_q.pend[i]) low_idx = AW'(i);
        low_oh  = s_q.pend & (~s_q.pend + N_ELEM'(1));
        full    = (s_q.cnt == CW'(FIFO_DEPTH));
        pop     = (s_q.cnt != '0) && out_ack;
        push    = found && !full;
        drop    = found && full;

        s_d.pend = (s_q.pend & ~low_oh) | leave;
        if (push) begin
            s_d.mem[s_q.wr] = low_idx;
            s_d.wr = (s_q.wr == PW'(FIFO_DEPTH - 1)) ? '0 : s_q.wr + PW'(1);
        end
        if (pop)
            s_d.rd = (s_q.rd == PW'(FIFO_DEPTH - 1)) ? '0 : s_q.rd + PW'(1);
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        if (drop && s_q.ovf != '1)
            s_d.ovf = s_q.ovf + OVF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_req   = (s_q.cnt != '0);
    assign out_addr  = s_q.mem[s_q.rd];
    assign ovf_count = s_q.ovf;

    // R8: occupancy never exceeds the queue depth
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(FIFO_DEPTH));

    // R8: an event offered to a full queue bumps the drop count by one
    assert_drop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (found && full && s_q.ovf != '1) |=> (s_q.ovf == $past(s_q.ovf) + OVF_W'(1)));

    // R7: an unaccepted head stays offered and unchanged
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> (out_req && $stable(out_addr)));
endmodule

// File: rtl/event_delay_line.sv
module event_delay_line #(
    parameter int N_ELEM     = 880,
    parameter int STAGES     = 16,
    parameter int UNIT_W     = 8,
    parameter int UNIT_RST   = 1,
    parameter int FIFO_DEPTH = 8,
    parameter int OVF_W      = 16,
    localparam int AW        = $clog2(N_ELEM + 1),
    localparam int N_WORDS   = (N_ELEM - 1 + edl_pkg::CFG_DW - 1) / edl_pkg::CFG_DW,
    localparam int SEL_W     = $clog2(N_WORDS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [AW-1:0]              in_addr,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [edl_pkg::CFG_DW-1:0] cfg_wdata,
    output logic                       out_req,
    input  logic                       out_ack,
    output logic [AW-1:0]              out_addr,
    output logic [OVF_W-1:0]           ovf_count
);
    logic [UNIT_W-1:0] unit;
    logic              unit_load;
    logic [N_ELEM-2:0] cut;
    logic [N_ELEM-1:0] leave;

    edl_cfg #(
        .N_ELEM(N_ELEM), .UNIT_W(UNIT_W), .UNIT_RST(UNIT_RST), .SEL_W(SEL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .unit(unit), .unit_load(unit_load), .cut(cut)
    );

    edl_cascade #(
        .N_ELEM(N_ELEM), .STAGES(STAGES), .UNIT_W(UNIT_W), .AW(AW)
    ) u_cascade (
        .clk(clk), .rst_n(rst_n), .unit(unit), .unit_load(unit_load), .cut(cut),
        .inj_valid(in_valid), .inj_addr(in_addr), .leave(leave)
    );

    edl_emit #(
        .N_ELEM(N_ELEM), .AW(AW), .FIFO_DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)
    ) u_emit (
        .clk(clk), .rst_n(rst_n), .leave(leave), .out_ack(out_ack),
        .out_req(out_req), .out_addr(out_addr), .ovf_count(ovf_count)
    );

    // R1: during reset nothing is offered downstream
    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !out_req);
endmodule

// File: tb/event_delay_line_bench.sv
`timescale 1ns/1ps
module event_delay_line_bench;
    localparam int N     = 40;
    localparam int STG   = 4;
    localparam int DEPTH = 4;
    localparam int AW    = $clog2(N + 1);
    localparam int NW    = (N - 1 + 31) / 32;
    localparam int SW    = $clog2(NW + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [AW-1:0] in_addr = '0;
    logic cfg_we = 0;
    logic [SW-1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic out_req, out_ack;
    logic [AW-1:0] out_addr;
    logic [7:0] ovf_count;

    event_delay_line #(.N_ELEM(N), .STAGES(STG), .UNIT_W(8), .UNIT_RST(1),
                       .FIFO_DEPTH(DEPTH), .OVF_W(8)) u_event_delay_line (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_req(out_req), .out_ack(out_ack), .out_addr(out_addr),
        .ovf_count(ovf_count));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string tag = "R1";
    int ack_mode = 0;
    int ack_cnt = 0;

    // reference model state
    bit m_occ[N];
    bit m_pend[N];
    bit m_cut[N-1];
    int m_q[$];
    int m_phase, m_unit, m_ovf;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_occ[i]) begin m_occ[i] = 0; m_pend[i] = 0; end
            foreach (m_cut[i]) m_cut[i] = 0;
            m_q.delete();
            m_phase = 0; m_unit = 1; m_ovf = 0;
        end else begin
            int qn, low;
            bit full, step;
            bit nocc[N];
            qn = m_q.size();
            full = (qn == DEPTH);
            if (qn > 0 && out_ack) void'(m_q.pop_front());
            low = -1;
            for (int i = N - 1; i >= 0; i--) if (m_pend[i]) low = i;
            if (low >= 0) begin
                m_pend[low] = 0;
                if (!full) m_q.push_back(low);
                else if (m_ovf < 255) m_ovf++;
            end
            step = (m_phase == STG * m_unit - 1);
            foreach (nocc[i]) nocc[i] = step ? 1'b0 : m_occ[i];
            if (step) begin
                for (int i = 0; i < N; i++) if (m_occ[i]) begin
                    m_pend[i] = 1;
                    if (i < N - 1 && !m_cut[i]) nocc[i+1] = 1;
                end
            end
            if (in_valid && int'(in_addr) < N) nocc[in_addr] = 1;
            foreach (m_occ[i]) m_occ[i] = nocc[i];
            if (cfg_we && cfg_sel == 0 && cfg_wdata[7:0] != 0) begin
                m_unit = int'(cfg_wdata[7:0]);
                m_phase = 0;
            end else m_phase = step ? 0 : m_phase + 1;
            if (cfg_we && int'(cfg_sel) >= 1 && int'(cfg_sel) <= NW)
                for (int b = 0; b < 32; b++) begin
                    int idx;
                    idx = (int'(cfg_sel) - 1) * 32 + b;
                    if (idx < N - 1) m_cut[idx] = cfg_wdata[b];
                end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        bit er;
        er = (m_q.size() > 0);
        chk(out_req == er, {tag, " out_req"}, out_req, er);
        if (er && out_req) chk(int'(out_addr) == m_q[0], {tag, " out_addr"}, out_addr, m_q[0]);
        chk(int'(ovf_count) == m_ovf, {tag, " ovf_count"}, ovf_count, m_ovf);
    end

    // consumer side: R7 handshake patterns
    always @(negedge clk) begin
        #1;
        ack_cnt++;
        case (ack_mode)
            0: out_ack = 1'b1;
            1: out_ack = 1'b0;
            default: out_ack = ack_cnt[0] & ack_cnt[1];
        endcase
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            in_valid = 0; cfg_we = 0;
        end
    endtask

    task automatic inject(input int a);
        @(negedge clk); #1;
        in_valid = 1; in_addr = AW'(a); cfg_we = 0;
    endtask

    task automatic wcfg(input int sel, input logic [31:0] d);
        @(negedge clk); #1;
        in_valid = 0; cfg_we = 1; cfg_sel = SW'(sel); cfg_wdata = d;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        out_ack = 1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset state at the ports
        chk(out_req == 0, "R1 reset out_req", out_req, 0);
        chk(ovf_count == 0, "R1 reset ovf_count", ovf_count, 0);
        idle(6);

        // R2 and R3: single pulse walks the whole line to the end (R4 last element)
        tag = "R3";
        inject(3); idle(160);
        // R2: out-of-range address does nothing
        tag = "R2";
        inject(45); inject(63); idle(20);
        chk(out_req == 0, "R2 out-of-range ignored", out_req, 0);

        // R4: cut boundary 10 and boundary 33 (second word, bit 1)
        tag = "R4";
        wcfg(1, 32'h0000_0400); wcfg(2, 32'h0000_0002);
        inject(7); inject(30); idle(60);
        // R10: out-of-range word index changes nothing
        tag = "R10";
        wcfg(3, 32'hFFFF_FFFF); inject(8); idle(40);
        wcfg(1, 32'h0); wcfg(2, 32'h0);

        // R5: merges by re-injection and by collision with a moving pulse
        tag = "R5";
        inject(5); inject(5); inject(6); inject(7); inject(8); idle(30);

        // R6: many pulses leave in one step, drained lowest first
        tag = "R6";
        inject(20); inject(2); inject(15); inject(11); idle(40);

        // R7: held and toggled acknowledge
        tag = "R7";
        ack_mode = 2;
        inject(1); inject(9); inject(4); idle(50);
        ack_mode = 1;
        inject(12); inject(13); idle(20);
        ack_mode = 0; idle(20);

        // R8: queue fills with acknowledge held low, then drains while still full
        tag = "R8";
        ack_mode = 1;
        inject(0); inject(2); inject(4); inject(6); inject(8); inject(10); inject(12);
        idle(30);
        chk(ovf_count != 0, "R8 drops counted", ovf_count, 1);
        ack_mode = 0; idle(60);

        // R9: unit length change, zero write ignored, step coinciding with injection
        tag = "R9";
        wcfg(0, 32'h0000_0003); inject(0); idle(5);
        wcfg(0, 32'h0000_0100); idle(3);
        inject(0); inject(1); inject(2); inject(3); inject(4); inject(5); inject(6);
        inject(7); inject(8); inject(9); inject(10); inject(11); inject(12);
        idle(200);
        wcfg(0, 32'h0000_0001); idle(200);
        ack_mode = 2; tag = "R6";
        for (int k = 0; k < 24; k++) inject((k * 7) % 40);
        idle(300);
        summary();
    end
endmodule